// File: doc/BRIEF.md
# SRAM Chip-Select Bus Cycle Generator

This block serves one external asynchronous SRAM chip-select space. It takes single read or write requests from the internal side and turns each into one complete external bus cycle. That cycle drives an address, an active-low chip select, an active-low read strobe, four active-low per-byte write enables, and a direction line that is low for writes. When the cycle ends, the block answers the internal side with a one-tick ready pulse, together with the captured read data.

A 32-bit timing register, written over a plain write port, shapes the cycle. Its fields set:
- the setup delay from chip select to strobe, in half bus-cycle steps;
- the length of the strobe window;
- the hold time after the strobe;
- a byte-lane mode bit, which decides which lines stay low for the whole cycle and which pulse only at the access point.

The block runs on a clock at twice the bus rate, so one tick of `clk` is half a bus cycle. The timing register must be written at least once before the space is used. Until then, requests are not served.

Top module: `sram_cs_cycle_gen`

## Requirements
- R1: After reset the timing register reads 32'h0000_0500 (access wait 10, all other fields zero). A write stores only bits 20, 12:11, 10:7, 6 and 1:0 (mask 32'h0010_1FC3). Every other bit reads as 0.
- R2: Before the first register write, a request starts no cycle: chip select stays high and ready stays low.
- R3: The strobe window starts 2*S+1 ticks after chip select falls, where S is the setup field in bits 12:11. Codes 0,1,2,3 give 1,3,5,7 ticks.
- R4: The strobe window lasts 2*(A+1) ticks, where A is the access wait field in bits 10:7.
- R5: After the strobe window, chip select stays low for 2*H more ticks, where H is the hold field in bits 1:0. Address and write data do not change while chip select is low.
- R6: With the mode bit (bit 20) at 0, a write drives the write-enable lanes to ~byte_enable during the strobe window only, and holds the direction line low for the whole cycle. A read touches neither the write enables nor the direction line.
- R7: With the mode bit at 1, the write-enable lanes are ~byte_enable for the whole cycle on both reads and writes. On a write, the direction line is low during the strobe window only.
- R8: The read strobe is low exactly during the strobe window of reads and never on writes. The data bus value on the last strobe tick is returned with ready.
- R9: Ready is high for exactly one tick: the first tick with chip select high after the cycle ends. That tick is 2*S+1 + 2*(A+1) + 2*H ticks after chip select fell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus rate |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Timing register write strobe |
| reg_wdata | input | 32 | Timing register write value |
| reg_rdata | output | 32 | Timing register read value |
| req_valid | input | 1 | Access request, taken when idle and configured |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables |
| req_ready | output | 1 | One-tick completion pulse |
| req_rdata | output | DATA_W | Read data, valid with req_ready |
| bus_addr | output | ADDR_W | External address |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_we_n | output | DATA_W/8 | Per-byte write enables, active low |
| bus_rdwr_n | output | 1 | Direction, low = write |
| bus_dout | output | DATA_W | External write data |
| bus_din | input | DATA_W | External read data |

## Verification
The assertions assume that `rst_n` is held low for at least two ticks at start-up. They also assume that the external data input is only sampled, never forced into the control path, so every strobe relation depends on the internal phase alone. The stimulus follows these conditions:
- The bench holds reset for three ticks.
- It raises `req_valid` for a single tick per access.
- It writes the timing register only while the block is idle, so each cycle runs with the settings that were in place when it was accepted.

// File: rtl/sram_cs_pkg.sv
// Shared definitions for the SRAM chip-select cycle generator.
// Assumes a fixed 32-bit timing register; field positions are fixed here.
package sram_cs_pkg;
    localparam int unsigned REG_W     = 32;
    localparam int unsigned BAS_BIT   = 20;
    localparam int unsigned SETUP_LSB = 11;
    localparam int unsigned WAIT_LSB  = 7;
    localparam int unsigned HOLD_LSB  = 0;
    localparam logic [REG_W-1:0] REG_WR_MASK = 32'h0010_1FC3;
    localparam logic [REG_W-1:0] REG_RESET   = 32'h0000_0500;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_DONE
    } phase_e;
endpackage

// File: rtl/sram_cs_wait_reg.sv
// Timing register: stores writable fields, clears reserved bits, and
// remembers whether software has written it since reset.
// Assumes writes arrive as single-tick strobes.
module sram_cs_wait_reg
    import sram_cs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             bas,
    output logic [1:0]       setup,
    output logic [3:0]       acc_wait,
    output logic [1:0]       hold,
    output logic             configured
);
    logic [REG_W-1:0] reg_q;
    logic             cfg_q;

    // Register storage with reserved-bit masking and configured flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= REG_RESET;
            cfg_q <= 1'b0;
        end else if (wr_en) begin
            reg_q <= wdata & REG_WR_MASK;
            cfg_q <= 1'b1;
        end
    end

    assign rdata      = reg_q;
    assign bas        = reg_q[BAS_BIT];
    assign setup      = reg_q[SETUP_LSB +: 2];
    assign acc_wait   = reg_q[WAIT_LSB +: 4];
    assign hold       = reg_q[HOLD_LSB +: 2];
    assign configured = cfg_q;
endmodule

// File: rtl/sram_cs_seq.sv
// Cycle sequencer: accepts one request when idle and configured, snapshots
// the timing fields and request, then steps setup, strobe, hold and done
// phases by counting half bus-cycle ticks. Captures read data on the last
// strobe tick. Assumes the timing fields stay valid at acceptance.
module sram_cs_seq
    import sram_cs_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned BE_W  = DATA_W / 8,
    localparam int unsigned CNT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cfg_bas,
    input  logic [1:0]        cfg_setup,
    input  logic [3:0]        cfg_wait,
    input  logic [1:0]        cfg_hold,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BE_W-1:0]   req_be,
    input  logic [DATA_W-1:0] bus_din,
    output phase_e            phase,
    output logic              write_q,
    output logic              bas_q,
    output logic [BE_W-1:0]   be_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);
    phase_e           ph_q;
    logic [CNT_W-1:0] cnt_q;
    logic [3:0]       wait_q;
    logic [1:0]       hold_q;
    logic             last_tick;

    assign last_tick = (cnt_q == '0);

    // Phase stepping and tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            unique case (ph_q)
                PH_IDLE: if (start) begin
                    ph_q  <= PH_SETUP;
                    cnt_q <= CNT_W'({cfg_setup, 1'b0});
                end
                PH_SETUP: if (last_tick) begin
                    ph_q  <= PH_STROBE;
                    cnt_q <= CNT_W'({wait_q, 1'b1});
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
                PH_STROBE: if (last_tick) begin
                    if (hold_q != 2'd0) begin
                        ph_q  <= PH_HOLD;
                        cnt_q <= CNT_W'({hold_q - 2'd1, 1'b1});
                    end else begin
                        ph_q <= PH_DONE;
                    end
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
                PH_HOLD: if (last_tick) begin
                    ph_q <= PH_DONE;
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // Snapshot of request and timing fields at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            bas_q   <= 1'b0;
            be_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            wait_q  <= '0;
            hold_q  <= '0;
        end else if (ph_q == PH_IDLE && start) begin
            write_q <= req_write;
            bas_q   <= cfg_bas;
            be_q    <= req_be;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            wait_q  <= cfg_wait;
            hold_q  <= cfg_hold;
        end
    end

    // Read data capture on the final strobe tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (ph_q == PH_STROBE && last_tick && !write_q) begin
            rdata_q <= bus_din;
        end
    end

    assign phase = ph_q;
endmodule

// File: rtl/sram_cs_strobe.sv
// Strobe shaper: decodes the sequencer phase into chip select, read strobe,
// per-lane write enables and direction, following the byte-lane mode bit.
// Assumes phase, direction and mode are registered upstream.
module sram_cs_strobe
    import sram_cs_pkg::*;
#(
    parameter int unsigned BE_W = 4
) (
    input  phase_e          phase,
    input  logic            write_q,
    input  logic            bas_q,
    input  logic [BE_W-1:0] be_q,
    output logic            cs_n,
    output logic            rd_n,
    output logic [BE_W-1:0] we_n,
    output logic            rdwr_n
);
    logic in_cycle;
    logic in_strobe;

    assign in_cycle  = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
    assign in_strobe = (phase == PH_STROBE);
    assign cs_n      = !in_cycle;
    assign rd_n      = !(in_strobe && !write_q);
    assign rdwr_n    = bas_q ? !(in_strobe && write_q) : !(in_cycle && write_q);

    // One write-enable decoder per byte lane.
    for (genvar i = 0; i < BE_W; i++) begin : g_lane
        assign we_n[i] = bas_q ? !(in_cycle && be_q[i])
                               : !(in_strobe && write_q && be_q[i]);
    end
endmodule

// File: rtl/sram_cs_cycle_gen.sv
// Top of the SRAM chip-select cycle generator: timing register, sequencer
// and strobe shaper. Runs on a clock at twice the bus rate. Assumes the
// register is written before the first request and not during a cycle.
module sram_cs_cycle_gen
    import sram_cs_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BE_W-1:0]   req_be,
    output logic              req_ready,
    output logic [DATA_W-1:0] req_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_cs_n,
    output logic              bus_rd_n,
    output logic [BE_W-1:0]   bus_we_n,
    output logic              bus_rdwr_n,
    output logic [DATA_W-1:0] bus_dout,
    input  logic [DATA_W-1:0] bus_din
);
    logic       f_bas;
    logic [1:0] f_setup;
    logic [3:0] f_wait;
    logic [1:0] f_hold;
    logic       cfg_seen;
    phase_e     phase;
    logic       write_q;
    logic       bas_q;
    logic [BE_W-1:0] be_q;

    sram_cs_wait_reg u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .bas        (f_bas),
        .setup      (f_setup),
        .acc_wait   (f_wait),
        .hold       (f_hold),
        .configured (cfg_seen)
    );

    sram_cs_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (req_valid && cfg_seen),
        .cfg_bas   (f_bas),
        .cfg_setup (f_setup),
        .cfg_wait  (f_wait),
        .cfg_hold  (f_hold),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .bus_din   (bus_din),
        .phase     (phase),
        .write_q   (write_q),
        .bas_q     (bas_q),
        .be_q      (be_q),
        .addr_q    (bus_addr),
        .wdata_q   (bus_dout),
        .rdata_q   (req_rdata)
    );

    sram_cs_strobe #(.BE_W(BE_W)) u_strobe (
        .phase   (phase),
        .write_q (write_q),
        .bas_q   (bas_q),
        .be_q    (be_q),
        .cs_n    (bus_cs_n),
        .rd_n    (bus_rd_n),
        .we_n    (bus_we_n),
        .rdwr_n  (bus_rdwr_n)
    );

    assign req_ready = (phase == PH_DONE);
endmodule

// File: rtl/sram_cs_checker.sv
// Property checker for the SRAM chip-select cycle generator, bound to the top.
// Assumes reset is held for at least two ticks at start-up.
module sram_cs_checker #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned BE_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [31:0]       reg_rdata,
    input logic              configured,
    input logic              req_ready,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_cs_n,
    input logic              bus_rd_n,
    input logic [BE_W-1:0]   bus_we_n,
    input logic              bus_rdwr_n
);
    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~32'h0010_1FC3) == 32'h0);

    assert_idle_until_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !configured |-> bus_cs_n);

    assert_setup_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_cs_n) |-> bus_rd_n);

    assert_strobe_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_rd_n) |=> !bus_rd_n);

    assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && $past(!bus_cs_n)) |-> $stable(bus_addr));

    assert_we_inside_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_n != '1) |-> !bus_cs_n);

    assert_rd_not_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> (bus_rdwr_n && !bus_cs_n));

    assert_ready_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    assert_ready_cs_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> bus_cs_n);
endmodule

bind sram_cs_cycle_gen sram_cs_checker #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_rdata  (reg_rdata),
    .configured (cfg_seen),
    .req_ready  (req_ready),
    .bus_addr   (bus_addr),
    .bus_cs_n   (bus_cs_n),
    .bus_rd_n   (bus_rd_n),
    .bus_we_n   (bus_we_n),
    .bus_rdwr_n (bus_rdwr_n)
);

// File: tb/sim_sram_cs_cycle_gen.sv
module sim_sram_cs_cycle_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        req_ready;
    logic [31:0] req_rdata;
    logic [31:0] bus_addr;
    logic        bus_cs_n;
    logic        bus_rd_n;
    logic [3:0]  bus_we_n;
    logic        bus_rdwr_n;
    logic [31:0] bus_dout;
    logic [31:0] bus_din;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    assign bus_din = bus_addr ^ 32'h3C3C_A5A5;

    sram_cs_cycle_gen u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_ready(req_ready), .req_rdata(req_rdata), .bus_addr(bus_addr),
        .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_we_n(bus_we_n),
        .bus_rdwr_n(bus_rdwr_n), .bus_dout(bus_dout), .bus_din(bus_din)
    );

    // {mode, setup[1:0], wait[3:0], hold[1:0], write, be[3:0]}
    localparam logic [13:0] VEC [12] = '{
        {1'b0, 2'd0, 4'd0,  2'd0, 1'b1, 4'hF},
        {1'b0, 2'd1, 4'd2,  2'd1, 1'b0, 4'hF},
        {1'b0, 2'd2, 4'd1,  2'd2, 1'b1, 4'h5},
        {1'b0, 2'd3, 4'd3,  2'd3, 1'b0, 4'h3},
        {1'b1, 2'd0, 4'd1,  2'd0, 1'b0, 4'hC},
        {1'b1, 2'd1, 4'd0,  2'd1, 1'b1, 4'hA},
        {1'b1, 2'd2, 4'd4,  2'd0, 1'b0, 4'h1},
        {1'b1, 2'd3, 4'd2,  2'd2, 1'b1, 4'h6},
        {1'b0, 2'd0, 4'd15, 2'd3, 1'b1, 4'h8},
        {1'b1, 2'd3, 4'd15, 2'd3, 1'b0, 4'hF},
        {1'b0, 2'd1, 4'd10, 2'd0, 1'b0, 4'h2},
        {1'b1, 2'd2, 4'd0,  2'd1, 1'b1, 4'h9}
    };

    task automatic chk_int(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_hex(input string req, input string what, input logic [31:0] act,
                           input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic write_reg(input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // One access with measured edge positions in half-cycle ticks.
    task automatic run_vec(input int idx, input logic [13:0] v);
        logic       bas   = v[13];
        logic [1:0] setup = v[12:11];
        logic [3:0] wt    = v[10:7];
        logic [1:0] hold  = v[6:5];
        logic       wr    = v[4];
        logic [3:0] be    = v[3:0];
        logic [31:0] a = 32'h0004_0000 + 32'(idx * 16);
        logic [31:0] d = 32'hC0DE_0000 | 32'(idx);
        int s_t = 2 * int'(setup) + 1;
        int w_t = 2 * (int'(wt) + 1);
        int h_t = 2 * int'(hold);
        int tot = s_t + w_t + h_t;
        int cs_cnt = 0, rd_st = -1, rd_len = 0, we_st = -1, we_len = 0;
        int rw_st = -1, rw_len = 0, rdy_t = -1, bad_lane = 0, bad_hold = 0;
        logic [31:0] rd_val = '0;
        int e_rd_st, e_rd_len, e_we_st, e_we_len, e_rw_st, e_rw_len;

        write_reg((32'(bas) << 20) | (32'(setup) << 11) | (32'(wt) << 7) | 32'(hold));
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        for (int t = 0; t < 100; t++) begin
            if (!bus_cs_n) begin
                cs_cnt++;
                if (bus_addr !== a || bus_dout !== d) bad_hold++;
            end
            if (!bus_rd_n) begin if (rd_st < 0) rd_st = t; rd_len++; end
            if (bus_we_n != 4'hF) begin
                if (we_st < 0) we_st = t;
                we_len++;
                if (bus_we_n !== ~be) bad_lane++;
            end
            if (!bus_rdwr_n) begin if (rw_st < 0) rw_st = t; rw_len++; end
            if (req_ready) begin
                rdy_t = t;
                rd_val = req_rdata;
                chk_int("R9", "cs high at ready", int'(bus_cs_n), 1);
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        chk_int("R9", "ready pulse width", int'(req_ready), 0);

        // Reference timing model.
        e_rd_st = wr ? -1 : s_t;  e_rd_len = wr ? 0 : w_t;
        if (!bas) begin
            e_we_st = wr ? s_t : -1; e_we_len = wr ? w_t : 0;
            e_rw_st = wr ? 0 : -1;   e_rw_len = wr ? tot : 0;
        end else begin
            e_we_st = 0;             e_we_len = tot;
            e_rw_st = wr ? s_t : -1; e_rw_len = wr ? w_t : 0;
        end

        chk_int("R3", "strobe start", bas ? (wr ? rw_st : rd_st) : (wr ? we_st : rd_st), s_t);
        chk_int("R4", "strobe length", bas ? (wr ? rw_len : rd_len) : (wr ? we_len : rd_len), w_t);
        chk_int("R5", "cs low ticks", cs_cnt, tot);
        chk_int("R5", "addr/data stable", bad_hold, 0);
        chk_int("R8", "rd start", rd_st, e_rd_st);
        chk_int("R8", "rd length", rd_len, e_rd_len);
        chk_int(bas ? "R7" : "R6", "we start", we_st, e_we_st);
        chk_int(bas ? "R7" : "R6", "we length", we_len, e_we_len);
        chk_int(bas ? "R7" : "R6", "we lanes", bad_lane, 0);
        chk_int(bas ? "R7" : "R6", "rdwr start", rw_st, e_rw_st);
        chk_int(bas ? "R7" : "R6", "rdwr length", rw_len, e_rw_len);
        chk_int("R9", "ready tick", rdy_t, tot);
        if (!wr) chk_hex("R8", "read data", rd_val, a ^ 32'h3C3C_A5A5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_hex("R1", "reset value", reg_rdata, 32'h0000_0500);
        chk_int("R2", "cs after reset", int'(bus_cs_n), 1);
        chk_int("R9", "ready after reset", int'(req_ready), 0);

        // R2: request before any register write must be ignored.
        req_valid = 1'b1; req_write = 1'b1; req_addr = 32'h1234; req_be = 4'hF;
        begin
            int lows = 0, rdys = 0;
            for (int t = 0; t < 20; t++) begin
                @(negedge clk);
                if (!bus_cs_n) lows++;
                if (req_ready) rdys++;
            end
            req_valid = 1'b0;
            chk_int("R2", "cs low before config", lows, 0);
            chk_int("R2", "ready before config", rdys, 0);
        end

        // R1: reserved bits clear.
        write_reg(32'hFFFF_FFFF);
        chk_hex("R1", "masked readback", reg_rdata, 32'h0010_1FC3);
        write_reg(32'h0000_0000);
        chk_hex("R1", "zero readback", reg_rdata, 32'h0000_0000);

        for (int i = 0; i < 12; i++) run_vec(i, VEC[i]);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule